// File: doc/BRIEF.md
# Reciprocal Frequency Counter

This block measures the frequency of a slow, asynchronous digital input. It does not count input edges over a fixed window. It opens its gate on an input rising edge and closes it on a later input rising edge, so the gate always spans a whole number of input periods. While the gate is open it counts the reference clock. The result is a pair of integers: the number of whole input periods and the number of reference cycles they took. Downstream logic divides one by the other. Because the gate follows the signal's own edges, the resolution is one reference period at any input frequency. A 100 MHz reference with a gate of about one second resolves a 100 kHz input to roughly a millihertz.

To use the block, place the gate length (in reference cycles) on `gate_cycles` and pulse `start`. The block arms, waits for the next synchronized rising edge, and then counts. Once the programmed gate time has passed, it stops on the next rising edge of the input. `done` then pulses for one cycle, and the two counts stay on the outputs until another measurement begins. If the input stops toggling, a stall watchdog ends the measurement and raises `overflow`.

Top module: `recip_freq_counter`

## Requirements
- R1: `sig_in` passes through SYNC_STAGES flip-flops in the reference domain, and only its low-to-high transitions count as input edges. High-to-low transitions never advance any count, whatever the duty cycle.
- R2: A `start` pulse seen while idle latches `gate_cycles` and arms the block. Both counters are cleared at the first synchronized rising edge after the pulse, and that edge is the start edge of the measurement.
- R3: `ref_count` advances by one on every reference cycle of the measurement. Its final value is the number of reference cycles between the start edge and the stop edge. For an input with a period of P reference cycles this equals N*P.
- R4: `period_count` counts the rising edges after the start edge, up to and including the stop edge (N).
- R5: The stop edge is the first input rising edge at which `ref_count` would exceed the latched gate length G. For a period P this gives N = floor(G/P)+1. G = 0 stops on the first period.
- R6: `done` is high for exactly one cycle, the cycle after the stop edge. Both counts then hold their values until the next start edge.
- R7: A `start` pulse and any change of `gate_cycles` while armed or measuring have no effect on the running measurement or its result.
- R8: If no rising edge arrives for STALL_LIMIT consecutive reference cycles while the block is armed or measuring, the measurement ends. `done` pulses with `overflow`=1, and `overflow` stays high until the next accepted `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference timebase clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Asynchronous signal under test |
| start | input | 1 | Request for one measurement |
| gate_cycles | input | GATE_W | Nominal gate length in reference cycles |
| period_count | output | CNT_W | Whole input periods inside the gate |
| ref_count | output | CNT_W | Reference cycles inside the gate |
| done | output | 1 | One-cycle pulse when the result is ready |
| overflow | output | 1 | Measurement ended because the input stalled |

## Verification
The bench builds the block with CNT_W=32, GATE_W=16, SYNC_STAGES=2 and STALL_LIMIT=300. With a 300-cycle stall window, both stall cases (no edge ever arrives, and the input dies mid-gate) finish in a few hundred cycles. Gate lengths of tens to hundreds of cycles let exact N and N*P results be checked for many gate-to-period ratios, including G=0, G just below a multiple of P, and an odd, asymmetric duty cycle. A spurious start paired with a shortened gate mid-run yields a result that differs from the correct one, so both forms of R7 interference become visible.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

   typedef enum logic [1:0] {
      RFC_IDLE = 2'd0,
      RFC_ARM  = 2'd1,
      RFC_RUN  = 2'd2
   } rfc_state_e;

endpackage

// File: rtl/rfc_edge_sync.sv
module rfc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);

   logic [STAGES-1:0] chain_q;
   logic              hist_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("rfc_edge_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= 1'b0;
      else        hist_q <= chain_q[STAGES-1];
   end

   assign rise_o = chain_q[STAGES-1] & ~hist_q;

endmodule

// File: rtl/rfc_up_counter.sv
module rfc_up_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (inc) q <= q + 1'b1;
   end

endmodule

// File: rtl/rfc_gate_timer.sv
module rfc_gate_timer #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         tick,
   output logic         expired_o
);

   logic [W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      rem_q <= '0;
      else if (load)                   rem_q <= load_val;
      else if (tick && rem_q != '0)    rem_q <= rem_q - 1'b1;
   end

   assign expired_o = (rem_q == '0);

endmodule

// File: rtl/rfc_stall_watch.sv
module rfc_stall_watch #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic trip_o
);

   localparam int SW = $clog2(LIMIT + 1);
   localparam logic [SW-1:0] LIM_V = SW'(LIMIT);

   logic [SW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (clr)                   cnt_q <= '0;
      else if (tick && cnt_q != LIM_V) cnt_q <= cnt_q + 1'b1;
   end

   assign trip_o = (cnt_q == LIM_V);

endmodule

// File: rtl/recip_freq_counter.sv
module recip_freq_counter
   import rfc_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int GATE_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int STALL_LIMIT = 200_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sig_in,
   input  logic              start,
   input  logic [GATE_W-1:0] gate_cycles,
   output logic [CNT_W-1:0]  period_count,
   output logic [CNT_W-1:0]  ref_count,
   output logic              done,
   output logic              overflow
);

   generate
      if (GATE_W > CNT_W) begin : g_bad_gate
         $error("recip_freq_counter: GATE_W must not exceed CNT_W");
      end
      if (STALL_LIMIT < 1) begin : g_bad_stall
         $error("recip_freq_counter: STALL_LIMIT must be positive");
      end
   endgenerate

   rfc_state_e        st_q;
   logic [GATE_W-1:0] gate_q;
   logic              done_q, ovf_q;
   logic              sig_rise, gate_expired, stall_trip;
   logic              arm_hit, running, active;

   rfc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (sig_in),
      .rise_o   (sig_rise)
   );

   assign arm_hit = (st_q == RFC_ARM) && sig_rise;
   assign running = (st_q == RFC_RUN);
   assign active  = (st_q != RFC_IDLE);

   rfc_up_counter #(.W(CNT_W)) u_ref_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (arm_hit),
      .inc   (running),
      .q     (ref_count)
   );

   rfc_up_counter #(.W(CNT_W)) u_per_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (arm_hit),
      .inc   (running && sig_rise),
      .q     (period_count)
   );

   rfc_gate_timer #(.W(GATE_W)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (arm_hit),
      .load_val  (gate_q),
      .tick      (running),
      .expired_o (gate_expired)
   );

   rfc_stall_watch #(.LIMIT(STALL_LIMIT)) u_stall (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!active || sig_rise),
      .tick   (active),
      .trip_o (stall_trip)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RFC_IDLE;
         gate_q <= '0;
         done_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            RFC_IDLE: begin
               if (start) begin
                  gate_q <= gate_cycles;
                  ovf_q  <= 1'b0;
                  st_q   <= RFC_ARM;
               end
            end
            RFC_ARM: begin
               if (sig_rise) begin
                  st_q <= RFC_RUN;
               end else if (stall_trip) begin
                  st_q   <= RFC_IDLE;
                  done_q <= 1'b1;
                  ovf_q  <= 1'b1;
               end
            end
            RFC_RUN: begin
               if (sig_rise && gate_expired) begin
                  st_q   <= RFC_IDLE;
                  done_q <= 1'b1;
               end else if (!sig_rise && stall_trip) begin
                  st_q   <= RFC_IDLE;
                  done_q <= 1'b1;
                  ovf_q  <= 1'b1;
               end
            end
            default: st_q <= RFC_IDLE;
         endcase
      end
   end

   assign done     = done_q;
   assign overflow = ovf_q;

endmodule

// File: rtl/rfc_checker.sv
module rfc_checker
   import rfc_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int GATE_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              done,
   input logic              overflow,
   input logic              rise,
   input rfc_state_e        st,
   input logic [GATE_W-1:0] gate_q,
   input logic [CNT_W-1:0]  ref_count,
   input logic [CNT_W-1:0]  period_count
);

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RFC_IDLE && !start) |=> ($stable(ref_count) && $stable(period_count))); // R6

   AST_REF_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RFC_RUN) |=> (ref_count == $past(ref_count) + 1'b1)); // R3

   AST_PERIOD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RFC_RUN && rise) |=> (period_count == $past(period_count) + 1'b1)); // R4

   AST_GATE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !overflow) |-> (ref_count > CNT_W'(gate_q))); // R5

   AST_RUN_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RFC_RUN) |=> (st != RFC_ARM)); // R7

   AST_GATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (st != RFC_IDLE) |=> $stable(gate_q)); // R7

   AST_OVF_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> done); // R8

endmodule

bind recip_freq_counter rfc_checker #(.CNT_W(CNT_W), .GATE_W(GATE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .done         (done),
   .overflow     (overflow),
   .rise         (sig_rise),
   .st           (st_q),
   .gate_q       (gate_q),
   .ref_count    (ref_count),
   .period_count (period_count)
);

// File: tb/sim_recip_freq_counter.sv
module sim_recip_freq_counter;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 32;
   localparam int GATE_W     = 16;
   localparam int STALL      = 300;

   // columns: gate, input period, expected periods, expected reference cycles
   localparam int NVEC = 7;
   localparam int VEC [NVEC][4] = '{
      '{100, 10, 11, 110},
      '{ 99, 10, 10, 100},
      '{  0,  7,  1,   7},
      '{ 50,  3, 17,  51},
      '{200, 64,  4, 256},
      '{  1,  2,  1,   2},
      '{ 80,  9,  9,  81}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sig_in = 1'b0;
   logic              start = 1'b0;
   logic [GATE_W-1:0] gate_cycles = '0;
   logic [CNT_W-1:0]  period_count, ref_count;
   logic              done, overflow;

   int n_chk = 0;
   int n_bad = 0;
   int per   = 0;
   int ph    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   recip_freq_counter #(
      .CNT_W(CNT_W), .GATE_W(GATE_W), .SYNC_STAGES(2), .STALL_LIMIT(STALL)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .start(start),
      .gate_cycles(gate_cycles), .period_count(period_count),
      .ref_count(ref_count), .done(done), .overflow(overflow)
   );

   // input generator: period per cycles, high for per/2 cycles
   always @(negedge clk) begin
      if (per == 0) begin
         sig_in <= 1'b0;
         ph     <= 0;
      end else begin
         ph     <= (ph + 1 >= per) ? 0 : ph + 1;
         sig_in <= (ph < per / 2);
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      bit seen = 1'b0;
      for (int i = 0; i < 6000 && !seen; i++) begin
         @(negedge clk);
         if (done) seen = 1'b1;
      end
      chk({req, " done seen"}, seen, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      chk("R6 reset done", done, 0);
      chk("R8 reset overflow", overflow, 0);
      chk("R3 reset ref_count", ref_count, 0);
      chk("R4 reset period_count", period_count, 0);
      rst_n = 1'b1;

      // table walk: R1 R2 R3 R4 R5 R6
      for (int v = 0; v < NVEC; v++) begin
         per = VEC[v][1];
         gate_cycles = GATE_W'(VEC[v][0]);
         repeat (5) @(negedge clk);
         pulse_start();
         wait_done("R2");
         chk("R4 period_count", period_count, VEC[v][2]);
         chk("R3 R5 ref_count", ref_count, VEC[v][3]);
         chk("R8 overflow clear", overflow, 0);
         @(negedge clk);
         chk("R6 done single cycle", done, 0);
         repeat (20) @(negedge clk);
         chk("R6 ref held", ref_count, VEC[v][3]);
         chk("R1 period held", period_count, VEC[v][2]);
      end

      // R7: spurious start and shorter gate during a run
      per = 10;
      gate_cycles = 16'd100;
      repeat (5) @(negedge clk);
      pulse_start();
      repeat (40) @(negedge clk);
      gate_cycles = 16'd20;
      pulse_start();
      wait_done("R7");
      chk("R7 ref unaffected", ref_count, 110);
      chk("R7 periods unaffected", period_count, 11);

      // R8: input never toggles
      per = 0;
      repeat (5) @(negedge clk);
      pulse_start();
      wait_done("R8 idle input");
      chk("R8 overflow no edge", overflow, 1);
      @(negedge clk);
      chk("R8 overflow held", overflow, 1);

      // R8: input dies in mid gate
      per = 10;
      gate_cycles = 16'd2000;
      repeat (5) @(negedge clk);
      pulse_start();
      repeat (100) @(negedge clk);
      per = 0;
      wait_done("R8 stall");
      chk("R8 overflow mid gate", overflow, 1);

      // R8: next accepted start clears overflow
      per = 8;
      gate_cycles = 16'd30;
      repeat (5) @(negedge clk);
      pulse_start();
      @(negedge clk);
      chk("R8 overflow cleared by start", overflow, 0);
      wait_done("R8 recovery");
      chk("R5 recovery ref", ref_count, 32);
      chk("R4 recovery periods", period_count, 4);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule